// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Encoder

This block gathers the interrupt events of two serial channels, called A and B. Each channel has four event types: a received character, a special receive condition, an empty transmit buffer, and a change on an external or status line. Every event passes through that channel's enable settings. If the event is enabled, it sets a pending latch. The latches stay set until a channel command clears them. The block sums the latches into a single interrupt request, which is gated by a master enable. It also shows the pending state of both channels as one status byte.

The block also computes an interrupt vector. The programmed vector value is shared by both channels. A read through channel A always returns that value unchanged. A read through channel B can replace three bits of the vector with a code for the highest-priority pending source. Which three bits are replaced depends on the status-placement control. A host uses the channel B vector to jump straight to the handler for the most urgent source. The host then writes a clear command to the channel that raised the request.

Top module: `sio_irq_vector`

## Requirements
- R1: `pend_stat` carries the pending state with this layout:
  - bit 5: A receive, set when either the A character latch or the A special latch is set.
  - bit 4: A transmit.
  - bit 3: A external.
  - bit 2: B receive, set when either the B character latch or the B special latch is set.
  - bit 1: B transmit.
  - bit 0: B external.
  - bits 7:6: always 0.
- R2: A transmit-empty event sets the transmit latch only when bit 1 of that channel's enable byte is 1. An external-change event sets the external latch only when bit 0 is 1.
- R3: Bits 4:3 of the enable byte select the receive mode:
  - 00: no receive event sets anything.
  - 01: a character sets the character latch only while the channel is armed. That character disarms the channel. Command 0x20 re-arms it.
  - 10: every character sets the character latch.
  - 11: characters are ignored.
  - In modes 01, 10 and 11, a special event sets the special latch.
- R4: A command strobe clears a latch on its own channel only:
  - 0x28 clears the transmit latch.
  - 0x10 clears the external latch.
  - 0x30 clears the special latch.
- R5: Command 0x38 on channel A clears the single highest-priority set latch, using the R8 order with special ahead of character inside each channel. Command 0x38 on channel B has no effect.
- R6: If an enabled event and the clear command for the same latch arrive in the same cycle, the latch ends up set.
- R7: `irq` is 1 exactly when control bit 3 (master enable) is 1 and at least one latch is set. `irq` is combinational from the latches.
- R8: The status code is 3 bits. The codes, listed from highest priority to lowest, are:
  - A special: 7.
  - A receive: 6.
  - A transmit: 4.
  - A external: 5.
  - B special: 3.
  - B receive: 2.
  - B transmit: 0.
  - B external: 1.
  - When nothing is pending, the code is 3.
- R9: `vec_rd_a` always equals `vec_base`. `vec_rd_b` equals `vec_base` when control bit 0 (vector-includes-status) is 0.
- R10: When control bit 0 is 1, `vec_rd_b` is `vec_base` with the code replacing one bit field:
  - If control bit 4 (status high) is 0, the code replaces bits 3:1.
  - If control bit 4 is 1, the code replaces bits 6:4.
- R11: After reset, every latch is clear and both channels are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char_a | input | 1 | Channel A character received pulse |
| rx_spcl_a | input | 1 | Channel A special receive condition pulse |
| tx_empty_a | input | 1 | Channel A transmit buffer empty pulse |
| ext_chg_a | input | 1 | Channel A external/status change pulse |
| rx_char_b | input | 1 | Channel B character received pulse |
| rx_spcl_b | input | 1 | Channel B special receive condition pulse |
| tx_empty_b | input | 1 | Channel B transmit buffer empty pulse |
| ext_chg_b | input | 1 | Channel B external/status change pulse |
| ien_a | input | 8 | Channel A enable byte (rx mode 4:3, tx 1, ext 0) |
| ien_b | input | 8 | Channel B enable byte (rx mode 4:3, tx 1, ext 0) |
| ctrl | input | 8 | Master control (bit 3 master enable, bit 0 include status, bit 4 status high) |
| vec_base | input | 8 | Programmed interrupt vector |
| cmd_we_a | input | 1 | Channel A command strobe |
| cmd_a | input | 8 | Channel A command code |
| cmd_we_b | input | 1 | Channel B command strobe |
| cmd_b | input | 8 | Channel B command code |
| irq | output | 1 | Interrupt request |
| pend_stat | output | 8 | Pending-status byte |
| vec_rd_a | output | 8 | Vector as read through channel A |
| vec_rd_b | output | 8 | Vector as read through channel B |

## Verification
An event and a command that clears the same latch can arrive in the same cycle. The bench provokes this collision on channel A by driving a transmit-empty pulse and command 0x28 together while the transmit latch is already set. It then checks that the latch reads as set afterwards (R6).

Command 0x38 on channel A can also clear a latch in the same cycle that other latches change. The bench therefore checks the pending byte after each 0x38 write. It confirms that only the highest-priority latch was removed.

A separate sweep covers all 64 combinations of character, transmit and external pending bits. For each combination it checks the request line and both vector reads under every setting of the three vectoring controls. The expected code is derived arithmetically from the channel and source.

// File: rtl/sio_irq_vector.sv
module sio_irq_vector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_char_a,
  input  logic       rx_spcl_a,
  input  logic       tx_empty_a,
  input  logic       ext_chg_a,
  input  logic       rx_char_b,
  input  logic       rx_spcl_b,
  input  logic       tx_empty_b,
  input  logic       ext_chg_b,
  input  logic [7:0] ien_a,
  input  logic [7:0] ien_b,
  input  logic [7:0] ctrl,
  input  logic [7:0] vec_base,
  input  logic       cmd_we_a,
  input  logic [7:0] cmd_a,
  input  logic       cmd_we_b,
  input  logic [7:0] cmd_b,
  output logic       irq,
  output logic [7:0] pend_stat,
  output logic [7:0] vec_rd_a,
  output logic [7:0] vec_rd_b
);
  localparam logic [7:0] CMD_TX_CLR  = 8'h28;
  localparam logic [7:0] CMD_EXT_CLR = 8'h10;
  localparam logic [7:0] CMD_SP_CLR  = 8'h30;
  localparam logic [7:0] CMD_TOP_CLR = 8'h38;
  localparam logic [7:0] CMD_REARM   = 8'h20;

  logic [1:0] ev_rx, ev_sp, ev_tx, ev_ex, we;
  logic [1:0][7:0] ien, cmd;
  logic [1:0] lat_rx, lat_sp, lat_tx, lat_ex, armed;
  logic [1:0] set_rx, set_sp, set_tx, set_ex;
  logic [1:0] clr_rx, clr_sp, clr_tx, clr_ex, rearm;
  logic [7:0] ord, top;
  logic [2:0] code;
  logic       top_clr;

  wire unused_bits = ^{ien_a[7:5], ien_a[2], ien_b[7:5], ien_b[2], ctrl[7:5], ctrl[2:1]};

  assign ev_rx = {rx_char_a, rx_char_b};
  assign ev_sp = {rx_spcl_a, rx_spcl_b};
  assign ev_tx = {tx_empty_a, tx_empty_b};
  assign ev_ex = {ext_chg_a, ext_chg_b};
  assign we    = {cmd_we_a, cmd_we_b};
  assign ien   = {ien_a, ien_b};
  assign cmd   = {cmd_a, cmd_b};

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      set_rx[c] = ev_rx[c] && (ien[c][4:3] == 2'b10 || (ien[c][4:3] == 2'b01 && armed[c]));
      set_sp[c] = ev_sp[c] && (ien[c][4:3] != 2'b00);
      set_tx[c] = ev_tx[c] && ien[c][1];
      set_ex[c] = ev_ex[c] && ien[c][0];
      rearm[c]  = we[c] && cmd[c] == CMD_REARM;
    end
  end

  assign ord     = {lat_sp[1], lat_rx[1], lat_tx[1], lat_ex[1],
                    lat_sp[0], lat_rx[0], lat_tx[0], lat_ex[0]};
  assign top_clr = cmd_we_a && cmd_a == CMD_TOP_CLR;

  always_comb begin
    top = 8'h00;
    for (int i = 0; i < 8; i++)
      if (ord[i]) top = 8'h01 << i;
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      clr_sp[c] = (we[c] && cmd[c] == CMD_SP_CLR)  || (top_clr && top[4*c+3]);
      clr_rx[c] =                                      top_clr && top[4*c+2];
      clr_tx[c] = (we[c] && cmd[c] == CMD_TX_CLR)  || (top_clr && top[4*c+1]);
      clr_ex[c] = (we[c] && cmd[c] == CMD_EXT_CLR) || (top_clr && top[4*c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_rx <= '0;
      lat_sp <= '0;
      lat_tx <= '0;
      lat_ex <= '0;
      armed  <= '1;
    end else begin
      lat_rx <= set_rx | (lat_rx & ~clr_rx);
      lat_sp <= set_sp | (lat_sp & ~clr_sp);
      lat_tx <= set_tx | (lat_tx & ~clr_tx);
      lat_ex <= set_ex | (lat_ex & ~clr_ex);
      for (int c = 0; c < 2; c++)
        if (rearm[c]) armed[c] <= 1'b1;
        else if (ev_rx[c] && ien[c][4:3] == 2'b01) armed[c] <= 1'b0;
    end
  end

  always_comb begin
    code = 3'd3;
    for (int c = 0; c < 2; c++) begin
      if (lat_ex[c]) code = {c[0], 2'b01};
      if (lat_tx[c]) code = {c[0], 2'b00};
      if (lat_rx[c]) code = {c[0], 2'b10};
      if (lat_sp[c]) code = {c[0], 2'b11};
    end
  end

  assign pend_stat = {2'b00, lat_rx[1] | lat_sp[1], lat_tx[1], lat_ex[1],
                      lat_rx[0] | lat_sp[0], lat_tx[0], lat_ex[0]};
  assign irq       = ctrl[3] && (ord != 8'h00);
  assign vec_rd_a  = vec_base;
  assign vec_rd_b  = !ctrl[0] ? vec_base :
                     ctrl[4]  ? {vec_base[7], code, vec_base[3:0]} :
                                {vec_base[7:4], code, vec_base[0]};
endmodule

module sio_irq_vector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_char_a,
  input logic       rx_spcl_a,
  input logic       tx_empty_a,
  input logic       ext_chg_a,
  input logic       rx_char_b,
  input logic       rx_spcl_b,
  input logic       tx_empty_b,
  input logic       ext_chg_b,
  input logic [7:0] ien_a,
  input logic [7:0] ctrl,
  input logic [7:0] vec_base,
  input logic       cmd_we_a,
  input logic [7:0] cmd_a,
  input logic       cmd_we_b,
  input logic [7:0] cmd_b,
  input logic       irq,
  input logic [7:0] pend_stat,
  input logic [7:0] vec_rd_a,
  input logic [7:0] vec_rd_b
);
  wire unused_chk = ^{ien_a[7:2], ien_a[0], ctrl[7:5], ctrl[2:1]};
  logic no_ev;
  assign no_ev = !(rx_char_a || rx_spcl_a || tx_empty_a || ext_chg_a ||
                   rx_char_b || rx_spcl_b || tx_empty_b || ext_chg_b);

  p_top_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n) pend_stat[7:6] == 2'b00);
  p_tx_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_stat[4]) |-> $past(tx_empty_a && ien_a[1]));
  p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_a && cmd_a == 8'h28 && !tx_empty_a) |=> !pend_stat[4]);
  p_b_top_clear_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_b && cmd_b == 8'h38 && !cmd_we_a && no_ev) |=> $stable(pend_stat));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty_a && ien_a[1]) |=> pend_stat[4]);
  p_irq_master_r7: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ctrl[3]);
  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && pend_stat != 8'h00) |-> irq);
  p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && ctrl[3] && ctrl[0] && !ctrl[4]) |-> vec_rd_b[3:1] == 3'd3);
  p_vec_a_r9: assert property (@(posedge clk) disable iff (!rst_n) vec_rd_a == vec_base);
  p_vec_b_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> vec_rd_b == vec_base);
endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (.*);

// File: tb/sio_irq_vector_test.sv
module sio_irq_vector_test;
  logic clk = 0, rst_n = 0;
  logic rx_char_a = 0, rx_spcl_a = 0, tx_empty_a = 0, ext_chg_a = 0;
  logic rx_char_b = 0, rx_spcl_b = 0, tx_empty_b = 0, ext_chg_b = 0;
  logic [7:0] ien_a = 0, ien_b = 0, ctrl = 0, vec_base = 0, cmd_a = 0, cmd_b = 0;
  logic cmd_we_a = 0, cmd_we_b = 0;
  logic irq;
  logic [7:0] pend_stat, vec_rd_a, vec_rd_b;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sio_irq_vector uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic ev(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    {rx_char_a, rx_spcl_a, tx_empty_a, ext_chg_a} = a;
    {rx_char_b, rx_spcl_b, tx_empty_b, ext_chg_b} = b;
    @(negedge clk);
    {rx_char_a, rx_spcl_a, tx_empty_a, ext_chg_a} = 0;
    {rx_char_b, rx_spcl_b, tx_empty_b, ext_chg_b} = 0;
  endtask

  task automatic cmd(input logic ch_a, input logic [7:0] code);
    @(negedge clk);
    if (ch_a) begin cmd_we_a = 1; cmd_a = code; end
    else begin cmd_we_b = 1; cmd_b = code; end
    @(negedge clk);
    cmd_we_a = 0; cmd_we_b = 0;
  endtask

  function automatic logic [2:0] ecode(input logic [5:0] m);
    ecode = 3'd3;
    for (int i = 0; i < 6; i++)
      if (m[i]) ecode = 3'((i / 3) * 4 + ((i % 3) == 2 ? 2 : (i % 3) == 1 ? 0 : 1));
  endfunction

  function automatic logic [7:0] evb(input logic [7:0] base, input logic [2:0] c,
                                     input logic vis, input logic hi);
    if (!vis) evb = base;
    else if (hi) evb = (base & 8'h8F) | {1'b0, c, 4'b0};
    else evb = (base & 8'hF1) | {4'b0, c, 1'b0};
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R11 reset pending", pend_stat, 8'h00);

    // R1 R7 R8 R9 R10 sweep
    for (int m = 0; m < 64; m++) begin
      do_reset();
      ien_a = 8'h13; ien_b = 8'h13; ctrl = 0;
      ev({m[5], 1'b0, m[4], m[3]}, {m[2], 1'b0, m[1], m[0]});
      chk("R1 pending layout", pend_stat, 8'(m));
      for (int cfg = 0; cfg < 8; cfg++) begin
        ctrl = {3'b0, cfg[2], cfg[1], 2'b0, cfg[0]};
        vec_base = 8'(m * 37 + cfg * 11 + 5);
        #1;
        chk("R7 irq", {7'b0, irq}, {7'b0, cfg[1] && m != 0});
        chk("R9 vec A", vec_rd_a, vec_base);
        chk("R10 vec B", vec_rd_b, evb(vec_base, ecode(6'(m)), cfg[0], cfg[2]));
      end
    end

    // R2 gating
    do_reset(); ien_a = 8'h10; ien_b = 8'h10; ctrl = 8'h09; vec_base = 8'h50;
    ev(4'b0011, 4'b0011);
    chk("R2 tx/ext disabled", pend_stat, 8'h00);
    ien_b = 8'h11;
    ev(4'b0000, 4'b0011);
    chk("R2 ext only enabled", pend_stat, 8'h01);

    // R3 modes
    do_reset(); ien_a = 8'h00;
    ev(4'b1100, 4'b0000);
    chk("R3 mode 00", pend_stat, 8'h00);
    ien_a = 8'h18;
    ev(4'b1000, 4'b0000);
    chk("R3 mode 11 char ignored", pend_stat, 8'h00);
    ev(4'b0100, 4'b0000);
    chk("R3 mode 11 special", pend_stat, 8'h20);
    chk("R8 A special code", vec_rd_b, 8'h5E);
    cmd(1, 8'h30);
    chk("R4 special clear", pend_stat, 8'h00);
    ien_a = 8'h08;
    ev(4'b1000, 4'b0000);
    chk("R3 first char", pend_stat, 8'h20);
    cmd(1, 8'h38);
    chk("R5 clear A rx", pend_stat, 8'h00);
    ev(4'b1000, 4'b0000);
    chk("R3 disarmed", pend_stat, 8'h00);
    cmd(1, 8'h20);
    ev(4'b1000, 4'b0000);
    chk("R3 rearmed", pend_stat, 8'h20);

    // R8 special over char in same channel
    ev(4'b0100, 4'b0000);
    chk("R8 special priority", vec_rd_b, 8'h5E);
    cmd(1, 8'h30);
    chk("R8 char after special", vec_rd_b, 8'h5C);
    cmd(1, 8'h38);

    // R4 channel B clears, channel A untouched
    ien_a = 8'h13; ien_b = 8'h13;
    ev(4'b0011, 4'b0111);
    chk("R4 setup", pend_stat, 8'h1F);
    cmd(0, 8'h28);
    chk("R4 B tx clear", pend_stat, 8'h1D);
    cmd(0, 8'h10);
    chk("R4 B ext clear", pend_stat, 8'h1C);
    cmd(0, 8'h30);
    chk("R4 B special clear", pend_stat, 8'h18);

    // R5 channel B ignore, channel A priority order
    ev(4'b0000, 4'b0001);
    cmd(0, 8'h38);
    chk("R5 B ignored", pend_stat, 8'h19);
    cmd(1, 8'h38);
    chk("R5 A tx first", pend_stat, 8'h09);
    cmd(1, 8'h38);
    chk("R5 A ext next", pend_stat, 8'h01);
    cmd(1, 8'h38);
    chk("R5 B ext last", pend_stat, 8'h00);
    chk("R8 idle code", vec_rd_b, 8'h56);

    // R6 collision
    ev(4'b0010, 4'b0000);
    @(negedge clk);
    tx_empty_a = 1; cmd_we_a = 1; cmd_a = 8'h28;
    @(negedge clk);
    tx_empty_a = 0; cmd_we_a = 0;
    chk("R6 set wins", pend_stat, 8'h10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule